// File: doc/BRIEF.md
# Dual-Role Double-Buffered Serial Port Controller

This block is a 16-bit synchronous serial port that acts either as the clock-driving side or as the clock-following side of a four-wire link. A control bit picks the role. In the driving role, a programmable divider produces the serial clock, and an active-low select strobe frames each burst. In the following role, the serial clock arrives from outside and is resynchronised to the system clock. Both roles use one shift register. Outgoing data leaves from its top bit, and incoming bits enter at its bottom bit.

A host writes words through a small register port. A write to the shift register, or to the holding buffer, starts a transfer. A word left in the holding buffer while a transfer runs is loaded when the current word ends, so the serial clock runs on without a gap. Each finished word is masked to the programmed length, from 1 to 16 bits, and stored right-justified in a receive buffer. At the same time, a completion flag is set, and this flag can drive an interrupt.

Top module: `spi_dual_ctrl`

## Requirements
- R1: Control register (write address 0) bit 0 selects the role. When it is 1, the block drives `sclk_o`. When it is 0, `sclk_o` stays low and the serial clock is taken from `sclk_i`.
- R2: In the driving role, data leaves on `mosi_o` and is captured from `miso_i`, and `miso_o` is held low. In the following role, data leaves on `miso_o` and enters on `mosi_i`, and `mosi_o` is held low.
- R3: A write to address 2 (shift register) while idle starts a transfer. A write to address 3 (holding buffer) while idle also starts one. Bit 15 is sent first, and received bits enter at bit 0.
- R4: Control bits [7:4] hold the word length minus one. After that many bits, the receive buffer (read address 1) holds the received bits right-justified, with the upper bits zero. The completion flag (status bit 0, read address 0) is then set.
- R5: If the holding buffer is full when a word ends, it is loaded and sent with the same clock period across the boundary, and the strobe stays low. Otherwise the serial clock stops low.
- R6: `irq_o` is high exactly while the completion flag is set and control bit 1 (interrupt enable) is 1.
- R7: The rate register (write address 1, bits [6:0]) sets the serial clock period to divider+1 system clocks for values 3 to 127. Values 0, 1 and 2 give 4 system clocks.
- R8: In the driving role, `cs_n_o` goes low when a transfer starts, at least two system clocks before the first rising serial edge. It returns high when the last word ends. It stays high in the following role.
- R9: In the following role, `sclk_i` and `mosi_i` pass through a two-stage synchroniser. On each rising edge the block samples `mosi_i` and then presents the next bit on `miso_o`. This works for serial clocks up to one quarter of the system clock.
- R10: A read of address 1 clears the completion flag and the interrupt, but if a word completes in the same cycle the flag stays set. Status bit 1 (buffer full) clears when the holding buffer moves into the shift register.
- R11: A write to address 2 while a transfer is running is ignored, and the word in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 rate, 2 shift, 3 holding buffer |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host register read strobe |
| rd_addr | input | 2 | Read address: 0 status, 1 receive buffer, 2 control, 3 rate |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |
| sclk_o | output | 1 | Serial clock driven in the driving role |
| sclk_i | input | 1 | Serial clock received in the following role |
| mosi_o | output | 1 | Data out in the driving role |
| mosi_i | input | 1 | Data in for the following role |
| miso_o | output | 1 | Data out in the following role |
| miso_i | input | 1 | Data in for the driving role |
| cs_n_o | output | 1 | Active-low select strobe |
| irq_o | output | 1 | Completion interrupt |

## Verification
Completion of a word can land in the same system clock cycle as a host read of the receive buffer. The read tries to clear the completion flag while the shift engine sets it. The bench times a host read to the exact edge on which the last bit is shifted, counting from the write that started the transfer, the divider period and the word length. It expects the read to return the previous word, and it expects the flag to remain set so that a following read returns the new word. The holding-buffer hand-over is also checked at the word boundary: the clock period stays the same and the strobe stays low.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;
  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_RATE  = 2'd1,
    W_SHIFT = 2'd2,
    W_HOLD  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    R_STAT = 2'd0,
    R_RXB  = 2'd1,
    R_CTRL = 2'd2,
    R_RATE = 2'd3
  } rd_sel_e;

  localparam int MIN_DIV   = 3;
  localparam int LEN_LSB   = 4;
  localparam int SYNC_BITS = 2;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int DIVW    = 7,
  parameter int MIN_DIV = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            sclk_o,
  output logic            samp_p,
  output logic            shift_p
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_cnt;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] lo_len;

  always_comb begin
    top_cnt = (div < DIVW'(MIN_DIV)) ? CW'(MIN_DIV) : {1'b0, div};
    hi_len  = (top_cnt + 1'b1) >> 1;
    lo_len  = top_cnt + 1'b1 - hi_len;
    samp_p  = en && (cnt_q == lo_len - 1'b1);
    shift_p = en && (cnt_q == top_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (shift_p) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (samp_p) sclk_o <= 1'b1;
    end
  end

  p_edges_apart_r7: assert property (@(posedge clk) disable iff (rst)
    !(samp_p && shift_p));

  p_rise_on_sample_r7: assert property (@(posedge clk) disable iff (rst)
    samp_p |=> sclk_o);
endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign rise_o = s2_q[0] & ~s3_q[0];
  assign fall_o = ~s2_q[0] & s3_q[0];

  // R9: the external clock must hold each level for at least two system clocks
  p_slow_ext_clk_r9: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !fall_o);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] len_m1,
  input  logic          samp_ev,
  input  logic          shift_ev,
  input  logic          sin,
  input  logic          wr_shift,
  input  logic          wr_hold,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clr,
  output logic          sout,
  output logic          busy_o,
  output logic          full_o,
  output logic          done_o,
  output logic [DW-1:0] rxbuf_o
);
  logic [DW-1:0] sh_q, hold_q, rx_q, shifted, len_mask;
  logic          samp_q, busy_q, full_q, done_q, bit_in, last;
  logic [LW-1:0] cnt_q;

  always_comb begin
    for (int i = 0; i < DW; i++) len_mask[i] = (i <= int'(len_m1));
    bit_in  = samp_ev ? sin : samp_q;
    shifted = {sh_q[DW-2:0], bit_in};
    last    = busy_q && shift_ev && (cnt_q == len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      hold_q <= '0;
      rx_q   <= '0;
      samp_q <= 1'b0;
      busy_q <= 1'b0;
      full_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (rd_clr) done_q <= 1'b0;
      if (busy_q && samp_ev) samp_q <= sin;
      if (busy_q) begin
        if (shift_ev) begin
          if (last) begin
            rx_q   <= shifted & len_mask;
            done_q <= 1'b1;
            cnt_q  <= '0;
            if (full_q) begin
              sh_q   <= hold_q;
              full_q <= 1'b0;
            end else begin
              sh_q   <= shifted;
              busy_q <= 1'b0;
            end
          end else begin
            sh_q  <= shifted;
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (wr_shift) begin
        sh_q   <= wdata;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (full_q) begin
        sh_q   <= hold_q;
        full_q <= 1'b0;
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
      if (wr_hold) begin
        hold_q <= wdata;
        full_q <= 1'b1;
      end
    end
  end

  assign sout    = sh_q[DW-1];
  assign busy_o  = busy_q;
  assign full_o  = full_q;
  assign done_o  = done_q;
  assign rxbuf_o = rx_q;

  p_cmpl_flag_r4: assert property (@(posedge clk) disable iff (rst)
    last |=> done_q);

  p_rx_justified_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ((rx_q & ~len_mask) == '0));

  p_chain_handover_r10: assert property (@(posedge clk) disable iff (rst)
    (last && full_q && !wr_hold) |=> (!full_q && busy_q));

  p_stop_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (last && !full_q && !wr_hold) |=> !busy_q);

  p_inflight_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !shift_ev) |=> $stable(sh_q));
endmodule

// File: rtl/spi_dual_ctrl.sv
module spi_dual_ctrl
  import spi_dual_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DIVW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sclk_o,
  input  logic          sclk_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          cs_n_o,
  output logic          irq_o
);
  localparam int LW = $clog2(DW);

  logic            mode_q, ien_q;
  logic [LW-1:0]   len_m1_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   rd_q;

  logic            wr_shift, wr_hold, rd_clr;
  logic            r_samp, r_shift, r_sclk;
  logic [SYNC_BITS-1:0] s_dat;
  logic            s_rise, s_fall;
  logic            samp_ev, shift_ev, sin, sout;
  logic            busy, full, done;
  logic [DW-1:0]   rxbuf;

  assign wr_shift = wr_en && (wr_addr == W_SHIFT);
  assign wr_hold  = wr_en && (wr_addr == W_HOLD);
  assign rd_clr   = rd_en && (rd_addr == R_RXB);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      ien_q    <= 1'b0;
      len_m1_q <= '0;
      div_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == W_CTRL) begin
        mode_q   <= wr_data[0];
        ien_q    <= wr_data[1];
        len_m1_q <= wr_data[LEN_LSB +: LW];
      end
      if (wr_addr == W_RATE) div_q <= wr_data[DIVW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        R_STAT:  rd_q <= DW'({busy, full, done});
        R_RXB:   rd_q <= rxbuf;
        R_CTRL:  rd_q <= DW'({len_m1_q, 2'b00, ien_q, mode_q});
        default: rd_q <= DW'(div_q);
      endcase
    end
  end
  assign rd_data = rd_q;

  spi_rate_gen #(.DIVW(DIVW), .MIN_DIV(MIN_DIV)) u_rate (
    .clk     (clk),
    .rst     (rst),
    .en      (busy && mode_q),
    .div     (div_q),
    .sclk_o  (r_sclk),
    .samp_p  (r_samp),
    .shift_p (r_shift)
  );

  spi_edge_sync #(.W(SYNC_BITS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({mosi_i, sclk_i}),
    .sync_o  (s_dat),
    .rise_o  (s_rise),
    .fall_o  (s_fall)
  );

  // Follower samples and advances on the same synchronised rising edge
  assign samp_ev  = mode_q ? r_samp  : s_rise;
  assign shift_ev = mode_q ? r_shift : s_rise;
  assign sin      = mode_q ? miso_i  : s_dat[1];

  spi_shift_core #(.DW(DW), .LW(LW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .len_m1   (len_m1_q),
    .samp_ev  (samp_ev),
    .shift_ev (shift_ev),
    .sin      (sin),
    .wr_shift (wr_shift),
    .wr_hold  (wr_hold),
    .wdata    (wr_data),
    .rd_clr   (rd_clr),
    .sout     (sout),
    .busy_o   (busy),
    .full_o   (full),
    .done_o   (done),
    .rxbuf_o  (rxbuf)
  );

  assign sclk_o = r_sclk;
  assign mosi_o = mode_q & sout;
  assign miso_o = ~mode_q & sout;
  assign cs_n_o = ~(busy & mode_q);
  assign irq_o  = done & ien_q;

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !$past(mode_q)) |-> !sclk_o);

  p_sclk_parks_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !sclk_o);

  p_strobe_covers_clock_r8: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !$past(cs_n_o));
endmodule

// File: tb/spi_dual_ctrl_tb.sv
module spi_dual_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0]  len;
    logic [6:0]  div;
    logic [15:0] tx;
    logic [15:0] peer;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{5'd16, 7'd3,   16'hA5C3, 16'h3C5A},
    '{5'd8,  7'd0,   16'hF000, 16'h9600},
    '{5'd1,  7'd2,   16'h8000, 16'h8000},
    '{5'd12, 7'd6,   16'h1230, 16'hFED0},
    '{5'd5,  7'd127, 16'hB800, 16'h5000},
    '{5'd16, 7'd4,   16'hFFFF, 16'h0001},
    '{5'd3,  7'd9,   16'h6000, 16'hE000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
  logic [15:0] wr_data = 16'd0, rd_data;
  logic sclk_o, mosi_o, miso_o, cs_n_o, irq_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i;

  int checks = 0, fails = 0;

  // serial peer and clock monitor
  logic peer_load = 1'b0, mon_clr = 1'b0;
  logic [15:0] peer_word = 16'd0, peer_sh, peer_rx;
  logic sclk_d, cs_d;
  int cyc = 0, last_rise = 0, rises = 0, min_gap = 0, max_gap = 0, cs_rises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dual_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .cs_n_o(cs_n_o), .irq_o(irq_o)
  );

  assign miso_i = peer_sh[15];

  always @(posedge clk) begin
    int g;
    cyc    <= cyc + 1;
    sclk_d <= sclk_o;
    cs_d   <= cs_n_o;
    if (peer_load) begin
      peer_sh <= peer_word;
      peer_rx <= 16'd0;
    end else begin
      if (sclk_o && !sclk_d) peer_rx <= {peer_rx[14:0], mosi_o};
      if (!sclk_o && sclk_d) peer_sh <= {peer_sh[14:0], 1'b0};
    end
    if (mon_clr) begin
      rises <= 0; min_gap <= 32'h7fffffff; max_gap <= 0; cs_rises <= 0;
    end else begin
      if (sclk_o && !sclk_d) begin
        rises <= rises + 1;
        if (rises != 0) begin
          g = cyc - last_rise;
          if (g < min_gap) min_gap <= g;
          if (g > max_gap) max_gap <= g;
        end
        last_rise <= cyc;
      end
      if (cs_n_o && !cs_d) cs_rises <= cs_rises + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 20000; k++) begin
      hr(2'd0, s);
      if (!s[2]) break;
    end
  endtask

  task automatic arm_peer(input logic [15:0] w);
    @(negedge clk); peer_word = w; peer_load = 1'b1; mon_clr = 1'b1;
    @(negedge clk); peer_load = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic follower_xfer(input logic [15:0] w, input int len, input int half,
                               output logic [15:0] got);
    got = 16'd0;
    for (int i = 0; i < len; i++) begin
      mosi_i = w[15-i];
      repeat (half) @(negedge clk);
      sclk_i = 1'b1;
      got = {got[14:0], miso_o};
      repeat (half) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (half + 6) @(negedge clk);
  endtask

  function automatic logic [15:0] lmask(input int len);
    return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r, got;
    int per, len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1 sclk_o idle after reset", 32'(sclk_o), 32'd0);
    chk("R8 cs_n_o high after reset", 32'(cs_n_o), 32'd1);
    chk("R6 irq_o low after reset", 32'(irq_o), 32'd0);
    hr(2'd0, r); chk("R4 status clear after reset", 32'(r), 32'd0);
    hr(2'd1, r); chk("R4 rxbuf clear after reset", 32'(r), 32'd0);

    // vector table: driving role, single words
    foreach (VEC[v]) begin
      len = int'(VEC[v].len);
      per = (VEC[v].div < 7'd3) ? 4 : int'(VEC[v].div) + 1;
      hw(2'd0, 16'(((len - 1) << 4) | 1));
      hw(2'd1, 16'(VEC[v].div));
      arm_peer(VEC[v].peer);
      hw(2'd2, VEC[v].tx);
      wait_idle();
      hr(2'd0, r); chk("R4 done flag set", 32'(r[0]), 32'd1);
      hr(2'd1, r); chk("R4 rx right-justified", 32'(r), 32'(VEC[v].peer >> (16 - len)));
      chk("R3 msb-first out on mosi", 32'(peer_rx & lmask(len)), 32'(VEC[v].tx >> (16 - len)));
      chk("R1 serial clock pulse count", 32'(rises), 32'(len));
      if (len > 1) begin
        chk("R7 clock period max", 32'(max_gap), 32'(per));
        chk("R7 clock period min", 32'(min_gap), 32'(per));
      end
      chk("R8 strobe back high", 32'(cs_n_o), 32'd1);
      chk("R2 miso_o held low as driver", 32'(miso_o), 32'd0);
      hr(2'd0, r); chk("R10 read clears done", 32'(r[0]), 32'd0);
    end

    // R5 / R10: chained words through the holding buffer
    hw(2'd0, 16'h0071);            // driver, len 8
    hw(2'd1, 16'd4);               // period 5
    arm_peer(16'h5AC3);
    hw(2'd2, 16'hA500);
    hw(2'd3, 16'h3C00);
    hr(2'd0, r); chk("R10 buffer-full bit set", 32'(r[1]), 32'd1);
    repeat (40) @(negedge clk);
    hr(2'd0, r); chk("R10 buffer-full cleared on handover", 32'(r[1:0]), 32'h1);
    hr(2'd1, r); chk("R5 first chained word", 32'(r), 32'h005A);
    wait_idle();
    hr(2'd1, r); chk("R5 second chained word", 32'(r), 32'h00C3);
    chk("R5 both words on mosi", 32'(peer_rx), 32'h0000A53C);
    chk("R5 gapless clock max", 32'(max_gap), 32'd5);
    chk("R5 gapless clock min", 32'(min_gap), 32'd5);
    chk("R5 strobe rose once", 32'(cs_rises), 32'd1);
    chk("R5 clock count", 32'(rises), 32'd16);

    // R3 start through the holding buffer while idle
    arm_peer(16'hC000);
    hw(2'd3, 16'h8100);
    wait_idle();
    hr(2'd1, r); chk("R3 hold write starts transfer", 32'(r), 32'h00C0);
    chk("R3 hold word sent", 32'(peer_rx & 16'h00FF), 32'h0081);

    // R11: write to shift register while busy is ignored
    arm_peer(16'h0000);
    hw(2'd2, 16'h6900);
    repeat (6) @(negedge clk);
    hw(2'd2, 16'hFFFF);
    wait_idle();
    chk("R11 busy write ignored", 32'(peer_rx & 16'h00FF), 32'h0069);
    hr(2'd1, r);

    // R6: interrupt gating
    hw(2'd0, 16'h0073);            // driver, irq on, len 8
    arm_peer(16'h1100);
    hw(2'd2, 16'h2200);
    wait_idle();
    chk("R6 irq with enable", 32'(irq_o), 32'd1);
    hr(2'd1, r);
    chk("R10 irq cleared by rx read", 32'(irq_o), 32'd0);
    hw(2'd0, 16'h0071);
    arm_peer(16'h1100);
    hw(2'd2, 16'h2200);
    wait_idle();
    hr(2'd0, r); chk("R6 done set while disabled", 32'(r[0]), 32'd1);
    chk("R6 irq stays low while disabled", 32'(irq_o), 32'd0);
    hr(2'd1, r); chk("R4 rx value", 32'(r), 32'h0011);

    // R10: completion and rx read in the same cycle (len 4, period 4)
    hw(2'd0, 16'h0031);
    hw(2'd1, 16'd3);
    arm_peer(16'h9000);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h7000;
    @(negedge clk); wr_en = 1'b0;
    repeat (15) @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd1;
    @(negedge clk); rd_en = 1'b0; r = rd_data;
    chk("R10 same-cycle read returns previous word", 32'(r), 32'h0011);
    hr(2'd0, r); chk("R10 completion wins over clear", 32'(r[0]), 32'd1);
    hr(2'd1, r); chk("R10 new word after collision", 32'(r), 32'h0009);
    hr(2'd0, r); chk("R10 flag cleared afterwards", 32'(r[0]), 32'd0);

    // R9 / R2: following role, slow and fastest allowed clock
    hw(2'd0, 16'h00F0);            // follower, len 16
    arm_peer(16'h0000);
    hw(2'd2, 16'hA5C3);
    follower_xfer(16'h3C96, 16, 8, got);
    chk("R9 follower out on miso", 32'(got), 32'h0000A5C3);
    hr(2'd1, r); chk("R9 follower rx", 32'(r), 32'h3C96);
    chk("R1 no clock driven as follower", 32'(rises), 32'd0);
    chk("R8 strobe high as follower", 32'(cs_n_o), 32'd1);
    chk("R2 mosi_o held low as follower", 32'(mosi_o), 32'd0);
    hw(2'd0, 16'h0070);            // follower, len 8
    hw(2'd2, 16'hC600);
    follower_xfer(16'h8D00, 8, 2, got);
    chk("R9 follower out at quarter rate", 32'(got), 32'h000000C6);
    hr(2'd1, r); chk("R9 follower rx at quarter rate", 32'(r), 32'h008D);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule